// File: doc/BRIEF.md
# Saturating Event Counter Unit

A small performance-monitoring block that sits beside a cache controller and counts events for it. Two identical 32-bit counters each choose one event line from a vector of single-cycle pulses. They count only while a shared enable bit is set. When a counter reaches all-ones it stays there and does not wrap. Software reaches every register through a plain one-cycle read/write port. It can choose each counter's source, start and freeze counting as a whole, clear or preset a counter, and read a counter at any time.

The pulse vector carries fifteen event lines. Line k-1 belongs to source code k, and code 0 turns a counter off. Codes 1 to 9 are the base set. A parameter decides whether codes 10 to 15 count or see nothing. Each counter also has a two-bit interrupt mode. In one of its settings the counter drives a level interrupt while it is saturated.

Top module: `evt_sat_monitor`

## Requirements
- R1: After reset, every mapped register reads zero and `irq_out` is low.
- R2: The register offsets on `bus_addr` are 0x00 for control (bit 0 is the global enable, and it reads back as bit 0 only), 0x04 for counter 1 configuration, 0x08 for counter 0 configuration, 0x0C for the counter 1 value and 0x10 for the counter 0 value. The per-counter offsets fall by 4 for each step up in counter index. A read of any other offset returns zero, and a write to it changes no register.
- R3: A configuration register keeps the source code in bits [5:2] and the interrupt mode in bits [1:0]. A read returns those six bits and zeros above them.
- R4: A counter whose source code is k (1..15) rises by exactly one on each rising clock edge where the global enable is 1 and `evt_pulse[k-1]` is 1. Pulses on other lines leave it unchanged.
- R5: While the global enable is 0, neither counter changes except by a bus write.
- R6: Source code 0 disables a counter, whatever the pulse vector holds.
- R7: A counter that reaches 0xFFFFFFFF holds that value under further events.
- R8: A write to a value register loads the written data. It overrides an increment that falls in the same cycle.
- R9: With the default extended setting, source codes 0xA to 0xF count their lines in the same way as the base codes.
- R10: `irq_out` is high exactly while at least one counter has interrupt mode 01 and holds 0xFFFFFFFF. Modes 00, 10 and 11 never raise it.
- R11: The two counters work independently. Each follows only its own source, and both count when their sources pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe, else zero |
| evt_pulse | input | 15 | Event pulses, line k-1 belongs to source code k |
| irq_out | output | 1 | Level interrupt for saturated counters |

## Verification
A software write to a value register and an event increment of the same counter can land on the same clock edge. The bench provokes this by raising the selected event line and strobing a value write in the same cycle, then dropping both. It judges the result by reading the register back: the written data must appear, not the data plus one and not the old value plus one. A single event pulse after that must advance the counter from the written value.

// File: rtl/evtmon_pkg.sv
package evtmon_pkg;

  localparam int ADDR_W = 8;
  localparam int SRC_W  = 4;
  localparam int MODE_W = 2;
  localparam int CFG_W  = SRC_W + MODE_W;

  localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h00;
  localparam logic [ADDR_W-1:0] CFG0_OFS = 8'h08;
  localparam logic [ADDR_W-1:0] VAL0_OFS = 8'h10;
  localparam int                REG_STEP = 4;

  localparam logic [SRC_W-1:0]  SRC_OFF     = '0;
  localparam logic [MODE_W-1:0] IRQ_AT_FULL = 2'b01;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [MODE_W-1:0] mode;
  } cnt_cfg_t;

  // per-counter registers descend from the counter 0 slot
  function automatic logic [ADDR_W-1:0] cfg_ofs(input int unsigned idx);
    return CFG0_OFS - ADDR_W'(REG_STEP * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] val_ofs(input int unsigned idx);
    return VAL0_OFS - ADDR_W'(REG_STEP * idx);
  endfunction

endpackage

// File: rtl/evtmon_src_sel.sv
module evtmon_src_sel #(
  parameter int NUM_EVT    = 15,
  parameter int SRC_W      = 4,
  parameter int BASE_EVT   = 9,
  parameter bit EXT_EVENTS = 1'b1
) (
  input  logic [SRC_W-1:0]   src,
  input  logic [NUM_EVT-1:0] evt,
  output logic               hit
);
  localparam int TAB = 1 << SRC_W;

  logic [NUM_EVT-1:0] live;
  logic [TAB-1:0]     tab;

  generate
    if (EXT_EVENTS) begin : g_ext
      assign live = evt;
    end else begin : g_base
      logic unused_ext;
      assign unused_ext = ^evt[NUM_EVT-1:BASE_EVT];
      assign live = {{(NUM_EVT-BASE_EVT){1'b0}}, evt[BASE_EVT-1:0]};
    end
  endgenerate

  // code 0 lands on a constant zero slot
  assign tab = TAB'({live, 1'b0});
  assign hit = tab[src];

endmodule

// File: rtl/evtmon_counter.sv
module evtmon_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             step_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             full
);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v,
                                                input logic hit_i);
    return (hit_i && v != TOP) ? v + CNT_W'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else            cnt_q <= sat_step(cnt_q, step_en);
  end

  assign full = (cnt_q == TOP);

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_en) |=> full);

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !step_en) |=> $stable(cnt_q));

  // R8
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data)));

endmodule

// File: rtl/evt_sat_monitor.sv
module evt_sat_monitor
  import evtmon_pkg::*;
#(
  parameter int NUM_CNT    = 2,
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_EVT    = 15,
  parameter int BASE_EVT   = 9,
  parameter bit EXT_EVENTS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic              irq_out
);
  logic               wr_hit, rd_hit;
  logic               ctrl_wr;
  logic               ctrl_en;
  logic [NUM_CNT-1:0] cfg_wr, val_wr, sel_hit, step_en, full_vec, irq_vec;
  cnt_cfg_t           cfg_q  [NUM_CNT];
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:CFG_W];

  assign wr_hit  = bus_sel &  bus_wr;
  assign rd_hit  = bus_sel & ~bus_wr;
  assign ctrl_wr = wr_hit && (bus_addr == CTRL_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_en <= 1'b0;
    else if (ctrl_wr) ctrl_en <= bus_wdata[0];
  end

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      assign cfg_wr[i] = wr_hit && (bus_addr == cfg_ofs(i));
      assign val_wr[i] = wr_hit && (bus_addr == val_ofs(i));

      always_ff @(posedge clk) begin
        if (!rst_n)         cfg_q[i] <= '0;
        else if (cfg_wr[i]) cfg_q[i] <= cnt_cfg_t'(bus_wdata[CFG_W-1:0]);
      end

      evtmon_src_sel #(
        .NUM_EVT(NUM_EVT), .SRC_W(SRC_W),
        .BASE_EVT(BASE_EVT), .EXT_EVENTS(EXT_EVENTS)
      ) u_sel (
        .src(cfg_q[i].src), .evt(evt_pulse), .hit(sel_hit[i])
      );

      assign step_en[i] = ctrl_en & sel_hit[i];

      evtmon_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(val_wr[i]), .wr_data(CNT_W'(bus_wdata)),
        .step_en(step_en[i]),
        .cnt_q(cnt_arr[i]), .full(full_vec[i])
      );

      assign irq_vec[i] = full_vec[i] && (cfg_q[i].mode == IRQ_AT_FULL);

      // R6
      src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[i].src == SRC_OFF) |-> !sel_hit[i]);

      // R5
      gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !val_wr[i]) |=> $stable(cnt_arr[i]));
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      if (bus_addr == CTRL_OFS) bus_rdata = DATA_W'(ctrl_en);
      for (int i = 0; i < NUM_CNT; i++) begin
        if (bus_addr == cfg_ofs(i)) bus_rdata = DATA_W'(cfg_q[i]);
        if (bus_addr == val_ofs(i)) bus_rdata = DATA_W'(cnt_arr[i]);
      end
    end
  end

  assign irq_out = |irq_vec;

  // R2
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, cfg_wr, val_wr}));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|full_vec));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_out && !ctrl_en));

endmodule

// File: tb/evt_sat_monitor_bench.sv
module evt_sat_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [14:0] evt_pulse = '0;
  logic        irq_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  evt_sat_monitor u_evt_sat_monitor (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .irq_out(irq_out)
  );

  // monitor: pops one expectation per read strobe
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (bus_sel && !bus_wr) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: read with no expectation, actual %h", bus_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s: addr %h actual %h expected %h", t, bus_addr, bus_rdata, e);
          end
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [14:0] m, input int n);
    @(negedge clk);
    evt_pulse = m;
    repeat (n) @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s: irq_out actual %b expected %b", t, irq_out, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1");
    bus_read(8'h00, 32'h0, "R1");
    bus_read(8'h04, 32'h0, "R1");
    bus_read(8'h08, 32'h0, "R1");
    bus_read(8'h0C, 32'h0, "R1");
    bus_read(8'h10, 32'h0, "R1");
    // R2 unmapped offsets
    bus_write(8'h14, 32'h0000DEAD);
    bus_read(8'h14, 32'h0, "R2");
    bus_read(8'hFC, 32'h0, "R2");
    bus_read(8'h00, 32'h0, "R2");
    // R3 configuration fields
    bus_write(8'h08, 32'hFFFFFFCC);
    bus_read(8'h08, 32'h0000000C, "R3");
    bus_write(8'h04, 32'h00000015);
    bus_read(8'h04, 32'h00000015, "R3");
    chk_irq(1'b0, "R10");
    // R5 disabled globally
    pulse(15'h0004, 4);
    bus_read(8'h10, 32'd0, "R5");
    bus_write(8'h00, 32'hFFFFFFFF);
    bus_read(8'h00, 32'h1, "R2");
    // R4 / R11 counting
    pulse(15'h0004, 5);
    bus_read(8'h10, 32'd5, "R4");
    bus_read(8'h0C, 32'd0, "R11");
    pulse(15'h0010, 7);
    bus_read(8'h0C, 32'd7, "R11");
    bus_read(8'h10, 32'd5, "R11");
    pulse(15'h0015, 3);
    bus_read(8'h10, 32'd8, "R11");
    bus_read(8'h0C, 32'd10, "R11");
    pulse(15'h000B, 4);
    bus_read(8'h10, 32'd8, "R4");
    bus_read(8'h0C, 32'd10, "R4");
    // R5 freeze again
    bus_write(8'h00, 32'h0);
    pulse(15'h0014, 6);
    bus_read(8'h10, 32'd8, "R5");
    bus_read(8'h0C, 32'd10, "R5");
    bus_write(8'h00, 32'h1);
    // R6 source off
    bus_write(8'h08, 32'h0);
    pulse(15'h7FFF, 4);
    bus_read(8'h10, 32'd8, "R6");
    bus_read(8'h0C, 32'd14, "R11");
    // R9 extended codes
    bus_write(8'h08, 32'h3C);
    pulse(15'h4000, 3);
    bus_read(8'h10, 32'd11, "R9");
    bus_write(8'h08, 32'h28);
    pulse(15'h0200, 2);
    bus_read(8'h10, 32'd13, "R9");
    // R8 write, then write colliding with an increment
    bus_write(8'h10, 32'h0);
    bus_read(8'h10, 32'd0, "R8");
    @(negedge clk);
    evt_pulse = 15'h0200;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'd100;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; evt_pulse = '0;
    bus_read(8'h10, 32'd100, "R8");
    pulse(15'h0200, 1);
    bus_read(8'h10, 32'd101, "R4");
    // R7 / R10 saturation
    bus_write(8'h0C, 32'hFFFFFFFD);
    chk_irq(1'b0, "R10");
    pulse(15'h0010, 5);
    bus_read(8'h0C, 32'hFFFFFFFF, "R7");
    chk_irq(1'b1, "R10");
    pulse(15'h0010, 2);
    bus_read(8'h0C, 32'hFFFFFFFF, "R7");
    bus_write(8'h04, 32'h14);
    chk_irq(1'b0, "R10");
    bus_write(8'h04, 32'h16);
    chk_irq(1'b0, "R10");
    bus_write(8'h0C, 32'h12345678);
    bus_read(8'h0C, 32'h12345678, "R8");
    bus_write(8'h08, 32'h29);
    bus_write(8'h10, 32'hFFFFFFFF);
    chk_irq(1'b1, "R10");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule